// File: doc/BRIEF.md
# In-band interrupt flag bridge

This block carries one level-type interrupt flag across a character link inside the character stream itself. The transmit half accepts 8-bit characters with a control flag and an interrupt bit from a source. When the flag level it must convey differs from the last level it announced, it puts a control marker on the line ahead of that character. A marker for a 0-to-1 change uses code 8'h1C with the control flag set. A marker for a 1-to-0 change uses code 8'h7C with the control flag set. The character then follows one slot later from a one-entry holding register. The source sees ready/valid backpressure while that happens.

The receive half watches the incoming character stream. It strips both marker codes out of the data and drives a mirrored interrupt output from them. All other characters pass through with one cycle of latency.

Back pressure works in both directions. The local receive-buffer half-full level is ORed into the level that is announced to the far end. A received interrupt can halt the local transmitter when the `LOCAL_BP` parameter is set. A direct halt input also stops transmission. A halt never drops a character.

Top module: `irq_link_bridge`

## Requirements
- R1: After a synchronous active-low reset, `line_tx_valid`, `snk_valid` and `snk_irq` are 0, `src_ready` is 1, and the announced flag level is 0, so a first character with flag 0 goes out with no marker.
- R2: When an accepted character's level (`src_irq | rx_half`) is 1 and the last announced level is 0, the next line slot carries data 8'h1C with `line_tx_k`=1. The character itself follows in the line slot after that.
- R3: When an accepted character's level is 0 and the last announced level is 1, the next line slot carries 8'h7C with `line_tx_k`=1, followed by the character.
- R4: When the level is unchanged, an accepted character appears on `line_tx_*` in the next cycle. Back-to-back characters flow at one per cycle with `src_ready` held high.
- R5: In the cycle after a marker is inserted, `src_ready` is 0. No new character is taken until the held character has gone out.
- R6: A received 8'h1C with k=1 sets `snk_irq` in the next cycle. A received 8'h7C with k=1 clears it. In both cases `snk_valid` is 0 for that slot, so markers never reach the data output.
- R7: Any other valid received character appears on `snk_data`/`snk_k` with `snk_valid`=1 one cycle later. `snk_irq` is unchanged by it.
- R8: While `tx_halt` is 1, `src_ready` is 0 and `line_tx_valid` is 0 in the next cycle. A held character is kept and is sent once the halt clears.
- R9: With `LOCAL_BP`=1, a set `snk_irq` halts the transmitter in the same way as `tx_halt`.
- R10: `rx_half`=1 makes the announced level 1 even when `src_irq` is 0.
- R11: Levels that alternate on consecutive characters produce alternating markers, each followed by its own character, in order and with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_data | input | 8 | Character from the source |
| src_k | input | 1 | Control flag of the source character |
| src_irq | input | 1 | Interrupt level attached to the source character |
| src_valid | input | 1 | Source character present |
| src_ready | output | 1 | Bridge accepts the source character this cycle |
| tx_halt | input | 1 | Stop transmission |
| rx_half | input | 1 | Local receive buffer at least half full |
| line_tx_data | output | 8 | Outgoing line character |
| line_tx_k | output | 1 | Outgoing control flag |
| line_tx_valid | output | 1 | Outgoing slot holds a character |
| line_rx_data | input | 8 | Incoming line character |
| line_rx_k | input | 1 | Incoming control flag |
| line_rx_valid | input | 1 | Incoming slot holds a character |
| snk_data | output | 8 | Received data character |
| snk_k | output | 1 | Control flag of the received character |
| snk_valid | output | 1 | Received character present |
| snk_irq | output | 1 | Mirrored remote interrupt level |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a halt and a marker insertion whose character is still in the holding register. The bench raises `tx_halt` right after a level change and holds it for several cycles. It then expects the held character to come out exactly once after the halt drops. The second pair is a received 8'h1C and the local transmitter trying to send. The bench presents characters to the source right after injecting that marker, and its queue-based model requires that nothing leaves until 8'h7C arrives. Every cycle, the model also compares `src_ready`, both line outputs and the mirrored flag.

// File: rtl/irq_link_bridge.sv
module irq_link_bridge #(
  parameter int          W        = 8,
  parameter logic [7:0]  MARK_SET = 8'h1C,
  parameter logic [7:0]  MARK_CLR = 8'h7C,
  parameter bit          LOCAL_BP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_data,
  input  logic         src_k,
  input  logic         src_irq,
  input  logic         src_valid,
  output logic         src_ready,
  input  logic         tx_halt,
  input  logic         rx_half,
  output logic [W-1:0] line_tx_data,
  output logic         line_tx_k,
  output logic         line_tx_valid,
  input  logic [W-1:0] line_rx_data,
  input  logic         line_rx_k,
  input  logic         line_rx_valid,
  output logic [W-1:0] snk_data,
  output logic         snk_k,
  output logic         snk_valid,
  output logic         snk_irq
);

  localparam logic [W-1:0] SET_C = W'(MARK_SET);
  localparam logic [W-1:0] CLR_C = W'(MARK_CLR);

  logic         sent_lvl;
  logic         hold_v;
  logic [W-1:0] hold_d;
  logic         hold_k;

  wire halt  = tx_halt | (LOCAL_BP & snk_irq);
  wire lvl   = src_irq | rx_half;
  wire take  = src_valid & src_ready;
  wire flip  = take & (lvl != sent_lvl);
  wire rx_set = line_rx_valid & line_rx_k & (line_rx_data == SET_C);
  wire rx_clr = line_rx_valid & line_rx_k & (line_rx_data == CLR_C);

  assign src_ready = ~halt & ~hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_lvl      <= 1'b0;
      hold_v        <= 1'b0;
      hold_d        <= '0;
      hold_k        <= 1'b0;
      line_tx_valid <= 1'b0;
      line_tx_data  <= '0;
      line_tx_k     <= 1'b0;
    end else if (halt) begin
      line_tx_valid <= 1'b0;
    end else if (hold_v) begin
      line_tx_valid <= 1'b1;
      line_tx_data  <= hold_d;
      line_tx_k     <= hold_k;
      hold_v        <= 1'b0;
    end else if (flip) begin
      line_tx_valid <= 1'b1;
      line_tx_data  <= lvl ? SET_C : CLR_C;
      line_tx_k     <= 1'b1;
      sent_lvl      <= lvl;
      hold_v        <= 1'b1;
      hold_d        <= src_data;
      hold_k        <= src_k;
    end else if (take) begin
      line_tx_valid <= 1'b1;
      line_tx_data  <= src_data;
      line_tx_k     <= src_k;
    end else begin
      line_tx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snk_irq   <= 1'b0;
      snk_valid <= 1'b0;
      snk_data  <= '0;
      snk_k     <= 1'b0;
    end else begin
      snk_valid <= line_rx_valid & ~rx_set & ~rx_clr;
      if (rx_set) snk_irq <= 1'b1;
      else if (rx_clr) snk_irq <= 1'b0;
      if (line_rx_valid & ~rx_set & ~rx_clr) begin
        snk_data <= line_rx_data;
        snk_k    <= line_rx_k;
      end
    end
  end

endmodule

module irq_link_bridge_sva #(
  parameter int          W        = 8,
  parameter logic [7:0]  MARK_SET = 8'h1C,
  parameter logic [7:0]  MARK_CLR = 8'h7C,
  parameter bit          LOCAL_BP = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         src_ready,
  input logic         tx_halt,
  input logic         line_tx_valid,
  input logic [W-1:0] line_rx_data,
  input logic         line_rx_k,
  input logic         line_rx_valid,
  input logic [W-1:0] snk_data,
  input logic         snk_valid,
  input logic         snk_irq
);
  wire is_set = line_rx_valid && line_rx_k && line_rx_data == W'(MARK_SET);
  wire is_clr = line_rx_valid && line_rx_k && line_rx_data == W'(MARK_CLR);

  p_set_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> snk_irq && !snk_valid);
  p_clr_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> !snk_irq && !snk_valid);
  p_data_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_rx_valid && !is_set && !is_clr |=> snk_valid && snk_data == $past(line_rx_data) && $stable(snk_irq));
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |=> !line_tx_valid);
  p_halt_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |-> !src_ready);
  p_remote_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCAL_BP && snk_irq) |=> !line_tx_valid);
endmodule

bind irq_link_bridge irq_link_bridge_sva #(
  .W(W), .MARK_SET(MARK_SET), .MARK_CLR(MARK_CLR), .LOCAL_BP(LOCAL_BP)
) sva_i (
  .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .tx_halt(tx_halt),
  .line_tx_valid(line_tx_valid), .line_rx_data(line_rx_data),
  .line_rx_k(line_rx_k), .line_rx_valid(line_rx_valid),
  .snk_data(snk_data), .snk_valid(snk_valid), .snk_irq(snk_irq)
);

// File: tb/irq_link_bridge_tb_top.sv
module irq_link_bridge_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] src_data = '0;
  logic       src_k = 1'b0, src_irq = 1'b0, src_valid = 1'b0;
  logic       src_ready;
  logic       tx_halt = 1'b0, rx_half = 1'b0;
  logic [7:0] line_tx_data;
  logic       line_tx_k, line_tx_valid;
  logic [7:0] line_rx_data = '0;
  logic       line_rx_k = 1'b0, line_rx_valid = 1'b0;
  logic [7:0] snk_data;
  logic       snk_k, snk_valid, snk_irq;

  irq_link_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_data(src_data), .src_k(src_k), .src_irq(src_irq),
    .src_valid(src_valid), .src_ready(src_ready),
    .tx_halt(tx_halt), .rx_half(rx_half),
    .line_tx_data(line_tx_data), .line_tx_k(line_tx_k), .line_tx_valid(line_tx_valid),
    .line_rx_data(line_rx_data), .line_rx_k(line_rx_k), .line_rx_valid(line_rx_valid),
    .snk_data(snk_data), .snk_k(snk_k), .snk_valid(snk_valid), .snk_irq(snk_irq)
  );

  int total = 0, bad = 0;
  string cur_req = "R1";

  logic [9:0] sq[$];   // {irq, k, data} waiting at the source
  logic [8:0] mq[$];   // {k, data} expected on the line
  logic       m_lvl = 1'b0, m_irq = 1'b0;
  logic       e_txv = 1'b0, e_rxv = 1'b0;
  logic [8:0] e_tx = '0, e_rx = '0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit halt, rdy, set_m, clr_m;
    logic lvl;
    @(negedge clk);
    if (sq.size() > 0) begin
      src_valid = 1'b1;
      {src_irq, src_k, src_data} = sq[0];
    end else begin
      src_valid = 1'b0;
    end
    #1;
    halt = tx_halt || m_irq;
    rdy  = !halt && mq.size() == 0;
    chk(src_ready == rdy, "src_ready", src_ready, rdy);
    e_txv = 1'b0;
    if (!halt) begin
      if (rdy && src_valid) begin
        lvl = src_irq | rx_half;
        if (lvl != m_lvl) begin
          mq.push_back({1'b1, lvl ? 8'h1C : 8'h7C});
          m_lvl = lvl;
        end
        mq.push_back({src_k, src_data});
        void'(sq.pop_front());
      end
      if (mq.size() > 0) begin
        e_txv = 1'b1;
        e_tx = mq.pop_front();
      end
    end
    set_m = line_rx_valid && line_rx_k && line_rx_data == 8'h1C;
    clr_m = line_rx_valid && line_rx_k && line_rx_data == 8'h7C;
    e_rxv = line_rx_valid && !set_m && !clr_m;
    if (e_rxv) e_rx = {line_rx_k, line_rx_data};
    if (set_m) m_irq = 1'b1;
    if (clr_m) m_irq = 1'b0;
    @(posedge clk);
    #1;
    chk(line_tx_valid == e_txv, "line_tx_valid", line_tx_valid, e_txv);
    if (e_txv) chk({line_tx_k, line_tx_data} == e_tx, "line_tx char", {line_tx_k, line_tx_data}, e_tx);
    chk(snk_valid == e_rxv, "snk_valid", snk_valid, e_rxv);
    if (e_rxv) chk({snk_k, snk_data} == e_rx, "snk char", {snk_k, snk_data}, e_rx);
    chk(snk_irq == m_irq, "snk_irq", snk_irq, m_irq);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && (sq.size() > 0 || mq.size() > 0); i++) tick();
    tick();
  endtask

  task automatic rxin(input logic v, input logic k, input logic [7:0] d);
    @(negedge clk);
    line_rx_valid = v; line_rx_k = k; line_rx_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    cur_req = "R1";
    chk(line_tx_valid == 1'b0, "reset line_tx_valid", line_tx_valid, 0);
    chk(snk_valid == 1'b0, "reset snk_valid", snk_valid, 0);
    chk(snk_irq == 1'b0, "reset snk_irq", snk_irq, 0);
    chk(src_ready == 1'b1, "reset src_ready", src_ready, 1);
    sq.push_back({1'b0, 1'b0, 8'hA5});
    drain();

    cur_req = "R4";
    for (int i = 0; i < 6; i++) sq.push_back({1'b0, 1'b0, 8'(8'h10 + i)});
    sq.push_back({1'b0, 1'b1, 8'hBC});
    drain();

    cur_req = "R2";
    sq.push_back({1'b1, 1'b0, 8'h31});
    sq.push_back({1'b1, 1'b0, 8'h32});
    drain();

    cur_req = "R3";
    sq.push_back({1'b0, 1'b0, 8'h41});
    sq.push_back({1'b0, 1'b0, 8'h42});
    drain();

    cur_req = "R5";
    sq.push_back({1'b1, 1'b0, 8'h51});
    tick(); tick(); tick();
    drain();

    cur_req = "R11";
    for (int i = 0; i < 8; i++) sq.push_back({i[0] ? 1'b0 : 1'b1, 1'b0, 8'(8'h60 + i)});
    drain();

    cur_req = "R8";
    sq.push_back({1'b1, 1'b0, 8'h71});
    sq.push_back({1'b1, 1'b0, 8'h72});
    tick();
    tx_halt = 1'b1;
    tick(); tick(); tick();
    tx_halt = 1'b0;
    drain();
    tx_halt = 1'b1;
    sq.push_back({1'b1, 1'b0, 8'h73});
    tick(); tick();
    tx_halt = 1'b0;
    drain();

    cur_req = "R6";
    rxin(1'b1, 1'b0, 8'h01);
    tick();
    line_rx_valid = 1'b1; line_rx_k = 1'b1; line_rx_data = 8'h1C;
    tick();
    line_rx_valid = 1'b1; line_rx_k = 1'b0; line_rx_data = 8'h1C;
    tick();
    line_rx_valid = 1'b1; line_rx_k = 1'b1; line_rx_data = 8'h7C;
    tick();

    cur_req = "R7";
    line_rx_valid = 1'b1; line_rx_k = 1'b1; line_rx_data = 8'hBC;
    tick();
    line_rx_valid = 1'b0; line_rx_data = 8'h1C; line_rx_k = 1'b1;
    tick();
    line_rx_valid = 1'b1; line_rx_k = 1'b0; line_rx_data = 8'h7C;
    tick();
    line_rx_valid = 1'b0;
    tick();

    cur_req = "R9";
    line_rx_valid = 1'b1; line_rx_k = 1'b1; line_rx_data = 8'h1C;
    tick();
    line_rx_valid = 1'b0;
    sq.push_back({1'b0, 1'b0, 8'h91});
    sq.push_back({1'b0, 1'b0, 8'h92});
    tick(); tick(); tick();
    line_rx_valid = 1'b1; line_rx_k = 1'b1; line_rx_data = 8'h7C;
    tick();
    line_rx_valid = 1'b0;
    drain();

    cur_req = "R10";
    rx_half = 1'b1;
    sq.push_back({1'b0, 1'b0, 8'hA1});
    sq.push_back({1'b0, 1'b0, 8'hA2});
    drain();
    rx_half = 1'b0;
    sq.push_back({1'b0, 1'b0, 8'hA3});
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule